// File: doc/BRIEF.md
# Packed Register-Write Command Stream Decoder

The decoder sits behind the fetch path of a primary command queue. It takes 32-bit command words one at a time over a valid/ready handshake and turns them into single register writes on a simple valid/ready register bus. Commands arrive in fixed five-word packets. The first word of a packet is a header that packs four 8-bit register indices. Each of the four words after it is a data value for one of those indices, taken in turn.

Each 8-bit index selects one of two register windows of 128 word-aligned registers. Its top bit picks the window and its low seven bits pick the word inside it. A fixed padding register lets software fill packet slots it does not need. The decoder drops those writes, so they never reach the bus. Writes into the upper half of the first window are execution-alias writes. They store their value like any other write and also close the current command batch. The decoder marks each one with a one-cycle pulse.

An idle output tells the fetch side when no packet is partly received and no write is waiting on the bus.

Top module: `cmd_stream_decoder`

## Requirements
- R1: While and right after a synchronous reset, `idle` is 1 and `wr_valid` is 0, and the next accepted command word is treated as a header.
- R2: A header word issues no write. The four data words after it are written in arrival order to the indices in header bits 7:0, 15:8, 23:16 and 31:24, in that order.
- R3: An index with bit 7 clear maps to byte address 0x1C00 + 4 × (index bits 6:0).
- R4: An index with bit 7 set maps to byte address 0x2C00 + 4 × (index bits 6:0).
- R5: A data word whose index maps to the padding address 0x1C54 (index 0x15) is dropped. No bus write is issued for it, and the packet goes on with the next slot.
- R6: A write whose address lies in 0x1D00 to 0x1DFF (index bit 7 clear, bit 6 set) is issued normally. `exec_pulse` is 1 exactly in the cycle when that write is accepted (`wr_valid` and `wr_ready` both 1), and is 0 in every other cycle.
- R7: While `wr_valid` is 1 and `wr_ready` is 0, `cmd_ready` is 0, and `wr_addr` and `wr_data` hold their values until the write is accepted.
- R8: `idle` is 1 only when the decoder waits for a header and no write is pending on the bus.
- R9: Every packet is exactly five words long. The word after a packet's fourth data word is decoded as a new header.
- R10: A data word that produces a write shows on `wr_valid`, `wr_addr` and `wr_data` in the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command word is offered |
| cmd_ready | output | 1 | Decoder can take a command word |
| cmd_word | input | 32 | Command word (header or data) |
| wr_valid | output | 1 | Register write is pending |
| wr_ready | input | 1 | Register bus takes the write |
| wr_addr | output | 16 | Register byte address |
| wr_data | output | 32 | Register write value |
| exec_pulse | output | 1 | The accepted write targets the execution alias |
| idle | output | 1 | No partial packet and no pending write |

## Verification
Directed packets separate the two windows: they use index values at both ends of each window, so a wrong base or a wrong scale shows up as a wrong address. A packet that mixes padding slots with real writes shows whether padding is dropped without the slots after it shifting or losing order. An execution-alias index next to its non-alias neighbour shows whether the pulse is tied to the right address range. A long constrained-random run then uses biased indices and a randomly stalling bus, with back-to-back packets. It checks every accepted write against a queue built from the requirements, and so separates correct backpressure and packet framing from dropped, duplicated or reordered writes.

// File: rtl/cmd_pkt_pkg.sv
package cmd_pkt_pkg;

    // Widths of the command stream and the register bus.
    parameter int CMD_W   = 32;
    parameter int IDX_W   = 8;
    parameter int SLOTS   = 4;
    parameter int REG_AW  = 16;

    // Register map constants used by the translator.
    parameter logic [REG_AW-1:0] WIN_LO_BASE = 16'h1C00;
    parameter logic [REG_AW-1:0] WIN_HI_BASE = 16'h2C00;
    parameter logic [REG_AW-1:0] PAD_ADDR    = 16'h1C54;
    parameter logic [REG_AW-1:0] EXEC_OFS    = 16'h0100;

    localparam int OFS_W    = IDX_W - 1;
    localparam int WIN_SPAN = 4 << OFS_W;

    typedef struct packed {
        logic [REG_AW-1:0] addr;
        logic [CMD_W-1:0]  data;
    } reg_wr_t;

    typedef struct packed {
        logic [REG_AW-1:0] addr;
        logic              pad;
        logic              exec;
    } idx_info_t;

    // Byte address of a word offset inside a window.
    function automatic logic [REG_AW-1:0] win_addr(
        input logic [REG_AW-1:0] base, input logic [OFS_W-1:0] ofs);
        logic [REG_AW-1:0] byte_ofs;
        byte_ofs = REG_AW'({ofs, 2'b00});
        return base + byte_ofs;
    endfunction

endpackage

// File: rtl/cmd_slot_tracker.sv
module cmd_slot_tracker
    import cmd_pkt_pkg::*;
#(
    parameter int W     = CMD_W,
    parameter int IW    = IDX_W,
    parameter int NSLOT = SLOTS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [W-1:0]  word,
    output logic          at_header,
    output logic [IW-1:0] cur_idx
);
    localparam int CNT_W = $clog2(NSLOT + 1);
    localparam int SEL_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NSLOT);

    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     hdr;
    logic [SEL_W-1:0] sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            hdr <= '0;
        end else if (take) begin
            if (cnt == '0) begin
                hdr <= word;
                cnt <= CNT_W'(1);
            end else if (cnt == LAST) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    always_comb begin
        at_header = (cnt == '0);
        sel       = SEL_W'(cnt - CNT_W'(1));
        cur_idx   = hdr[sel*IW +: IW];
    end

    // R9
    wrap_to_header_chk: assert property (@(posedge clk) disable iff (rst)
        (take && cnt == LAST) |=> (cnt == '0));
    // R2
    header_opens_chk: assert property (@(posedge clk) disable iff (rst)
        (take && cnt == '0) |=> (cnt == CNT_W'(1) && hdr == $past(word)));
endmodule

// File: rtl/cmd_index_xlate.sv
module cmd_index_xlate
    import cmd_pkt_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int AW = REG_AW
) (
    input  logic [IW-1:0] idx,
    output idx_info_t     info
);
    localparam int OW = IW - 1;
    localparam logic [AW-1:0] EXEC_LO = WIN_LO_BASE + EXEC_OFS;
    localparam logic [AW-1:0] EXEC_HI = WIN_LO_BASE + AW'(WIN_SPAN - 1);

    logic [AW-1:0] lo_addr;
    logic [AW-1:0] hi_addr;

    always_comb begin
        lo_addr   = win_addr(WIN_LO_BASE, idx[OW-1:0]);
        hi_addr   = win_addr(WIN_HI_BASE, idx[OW-1:0]);
        info.addr = idx[IW-1] ? hi_addr : lo_addr;
        info.pad  = (info.addr == PAD_ADDR);
        info.exec = (info.addr >= EXEC_LO) && (info.addr <= EXEC_HI);
    end
endmodule

// File: rtl/cmd_wr_stage.sv
module cmd_wr_stage
    import cmd_pkt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  reg_wr_t req,
    input  logic    req_exec,
    input  logic    out_ready,
    output logic    out_valid,
    output reg_wr_t out_req,
    output logic    out_exec
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_req   <= '0;
            out_exec  <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_req   <= req;
            out_exec  <= req_exec;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_req)));
    // R10
    load_shows_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (out_valid && out_req == $past(req)));
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
    import cmd_pkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [REG_AW-1:0] wr_addr,
    output logic [CMD_W-1:0]  wr_data,
    output logic              exec_pulse,
    output logic              idle
);
    logic             take;
    logic             at_header;
    logic [IDX_W-1:0] cur_idx;
    idx_info_t        info;
    logic             load;
    reg_wr_t          req;
    reg_wr_t          out_req;
    logic             out_exec;

    assign cmd_ready = !(wr_valid && !wr_ready);
    assign take      = cmd_valid && cmd_ready;

    cmd_slot_tracker #(.W(CMD_W), .IW(IDX_W), .NSLOT(SLOTS)) u_track (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .word      (cmd_word),
        .at_header (at_header),
        .cur_idx   (cur_idx)
    );

    cmd_index_xlate #(.IW(IDX_W), .AW(REG_AW)) u_xlate (
        .idx  (cur_idx),
        .info (info)
    );

    always_comb begin
        load     = take && !at_header && !info.pad;
        req.addr = info.addr;
        req.data = cmd_word;
    end

    cmd_wr_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .req       (req),
        .req_exec  (info.exec),
        .out_ready (wr_ready),
        .out_valid (wr_valid),
        .out_req   (out_req),
        .out_exec  (out_exec)
    );

    assign wr_addr    = out_req.addr;
    assign wr_data    = out_req.data;
    assign exec_pulse = wr_valid && wr_ready && out_exec;
    assign idle       = at_header && !wr_valid;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (idle && !wr_valid));
    // R7
    stall_block_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |-> !cmd_ready);
    // R5
    no_pad_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr != PAD_ADDR));
    // R8
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        idle |-> !wr_valid);
    // R3 R4
    window_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr[1:0] == 2'b00 &&
                      ((wr_addr >= 16'h1C00 && wr_addr <= 16'h1DFF) ||
                       (wr_addr >= 16'h2C00 && wr_addr <= 16'h2DFF))));
    // R6
    exec_range_chk: assert property (@(posedge clk) disable iff (rst)
        exec_pulse |-> (wr_addr >= 16'h1D00 && wr_addr <= 16'h1DFF));
endmodule

// File: tb/tb_cmd_stream_decoder.sv
`timescale 1ns/1ps
module tb_cmd_stream_decoder;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [31:0] cmd_word;
    logic        wr_valid;
    logic        wr_ready;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic        exec_pulse;
    logic        idle;

    always #2 clk = ~clk;

    cmd_stream_decoder dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_word(cmd_word), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .exec_pulse(exec_pulse),
        .idle(idle)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int rdy_mode = 0;   // 0: always ready, 1: random, 2: held low
    logic [48:0] exp_q[$];

    function automatic logic [15:0] exp_addr(input logic [7:0] idx);
        logic [15:0] base;
        base = idx[7] ? 16'h2C00 : 16'h1C00;
        return base + 16'(idx[6:0]) * 16'd4;
    endfunction

    function automatic logic exp_exec(input logic [15:0] a);
        return (a >= 16'h1D00) && (a <= 16'h1DFF);
    endfunction

    function automatic logic [7:0] pick_idx(input int unsigned r);
        case (r % 8)
            0: return 8'h15;
            1: return 8'h40 | 8'(r >> 8 & 32'h3F);
            2: return 8'h80 | 8'(r >> 8);
            default: return 8'(r >> 8);
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Bus-ready driver: changes 1 ns after the rising edge.
    always @(posedge clk) begin
        #1;
        if (rdy_mode == 0) wr_ready = 1'b1;
        else if (rdy_mode == 2) wr_ready = 1'b0;
        else wr_ready = ($urandom % 4) != 0;
    end

    // Write monitor on the falling edge.
    logic        prev_stall = 1'b0;
    logic [15:0] prev_addr;
    logic [31:0] prev_data;
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            if (prev_stall) begin
                check(wr_valid && wr_addr == prev_addr && wr_data == prev_data,
                      "R7", "held write", {wr_addr, wr_data}, {prev_addr, prev_data});
            end
            if (wr_valid && !wr_ready)
                check(!cmd_ready, "R7", "cmd_ready during stall", cmd_ready, 0);
            if (wr_valid)
                check(wr_addr != 16'h1C54, "R5", "padding issued", wr_addr, 0);
            if (!(wr_valid && wr_ready))
                check(!exec_pulse, "R6", "stray exec_pulse", exec_pulse, 0);
            if (wr_valid && wr_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2", "unexpected write", {wr_addr, wr_data}, 0);
                end else begin
                    logic [48:0] e;
                    e = exp_q.pop_front();
                    check(wr_addr == e[47:32] && wr_data == e[31:0],
                          e[47:44] == 4'h2 ? "R4/R2" : "R3/R2", "write",
                          {wr_addr, wr_data}, e[47:0]);
                    check(exec_pulse == e[48], "R6", "exec_pulse", exec_pulse, e[48]);
                end
            end
            prev_stall = wr_valid && !wr_ready;
            prev_addr  = wr_addr;
            prev_data  = wr_data;
        end else begin
            prev_stall = 1'b0;
        end
    end

    task automatic send(input logic [31:0] w);
        bit acc;
        cmd_valid = 1'b1;
        cmd_word  = w;
        do begin
            @(negedge clk);
            acc = cmd_ready;
            @(posedge clk);
            #1;
        end while (!acc);
        cmd_valid = 1'b0;
    endtask

    task automatic queue_pkt(input logic [31:0] hdr, input logic [31:0] d[4]);
        for (int s = 0; s < 4; s++) begin
            logic [15:0] a;
            a = exp_addr(hdr[s*8 +: 8]);
            if (a != 16'h1C54) exp_q.push_back({exp_exec(a), a, d[s]});
        end
    endtask

    task automatic send_pkt(input logic [31:0] hdr, input logic [31:0] d[4]);
        queue_pkt(hdr, d);
        send(hdr);
        for (int s = 0; s < 4; s++) send(d[s]);
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    // Watchdog.
    initial begin
        wait (cycles > 150000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d[4];
        logic [31:0] hdr;
        void'($urandom(32'd20240611));
        rst = 1'b1; cmd_valid = 1'b0; cmd_word = '0; wr_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check(idle && !wr_valid, "R1", "reset state", {idle, wr_valid}, 2'b10);
        @(posedge clk); #1;
        rst = 1'b0;

        // R2/R3/R4: window edges, order of slots.
        d = '{32'h1111_0001, 32'h2222_0002, 32'h3333_0003, 32'h4444_0004};
        hdr = {8'hFF, 8'h80, 8'h3F, 8'h00};
        queue_pkt(hdr, d);
        send(hdr);
        @(negedge clk);
        check(!wr_valid && !idle, "R2", "header gives no write", {wr_valid, idle}, 2'b00);
        @(posedge clk); #1;
        send(d[0]);
        @(negedge clk);
        // R10: write visible one cycle after acceptance
        check(wr_valid && wr_addr == 16'h1C00 && wr_data == d[0], "R10",
              "latency", {wr_valid, wr_addr}, {1'b1, 16'h1C00});
        @(posedge clk); #1;
        for (int s = 1; s < 4; s++) send(d[s]);
        drain();
        @(negedge clk);
        check(idle, "R8", "idle after packet", idle, 1);
        check(exp_q.size() == 0, "R3/R4", "writes outstanding", exp_q.size(), 0);
        @(posedge clk); #1;

        // R5: padding in slots 0 and 2; R9: back-to-back packets.
        d = '{32'hAAAA_0000, 32'hBBBB_0001, 32'hCCCC_0002, 32'hDDDD_0003};
        send_pkt({8'h82, 8'h15, 8'h05, 8'h15}, d);
        d = '{32'h0101_0101, 32'h0202_0202, 32'h0303_0303, 32'h0404_0404};
        send_pkt({8'h15, 8'h15, 8'h15, 8'h15}, d);
        @(negedge clk);
        check(idle && !wr_valid, "R5", "all-padding packet idle", {idle, wr_valid}, 2'b10);
        @(posedge clk); #1;
        d = '{32'h5555_5555, 32'h6666_6666, 32'h7777_7777, 32'h8888_8888};
        send_pkt({8'h40, 8'h3F, 8'h7F, 8'hC0}, d);   // R6 alias next to neighbour
        drain();
        check(exp_q.size() == 0, "R9", "framing", exp_q.size(), 0);

        // R7: stall holds write and blocks commands.
        rdy_mode = 2;
        @(posedge clk); #1;
        d = '{32'hDEAD_0001, 32'hDEAD_0002, 32'hDEAD_0003, 32'hDEAD_0004};
        hdr = {8'h01, 8'h02, 8'h83, 8'h04};
        queue_pkt(hdr, d);
        send(hdr);
        send(d[0]);
        repeat (3) @(posedge clk);
        #1;
        cmd_valid = 1'b1; cmd_word = d[1];
        @(negedge clk);
        check(!cmd_ready && wr_valid && wr_addr == 16'h1C10, "R7", "stalled",
              {cmd_ready, wr_valid, wr_addr}, {2'b01, 16'h1C10});
        check(!idle, "R8", "idle while pending", idle, 0);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        rdy_mode = 0;
        for (int s = 1; s < 4; s++) send(d[s]);
        drain();

        // Random phase with random bus stalls.
        rdy_mode = 1;
        for (int p = 0; p < 400; p++) begin
            hdr = {pick_idx($urandom), pick_idx($urandom),
                   pick_idx($urandom), pick_idx($urandom)};
            for (int s = 0; s < 4; s++) d[s] = $urandom;
            send_pkt(hdr, d);
            if ($urandom % 8 == 0) repeat ($urandom % 4) @(posedge clk);
            #0;
        end
        rdy_mode = 0;
        drain();
        check(exp_q.size() == 0, "R9", "random phase leftover", exp_q.size(), 0);
        @(negedge clk);
        check(idle, "R8", "final idle", idle, 1);

        // R1: reset in mid-packet restarts framing.
        @(posedge clk); #1;
        send(32'h0000_0000);
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check(idle, "R1", "idle after mid-packet reset", idle, 1);
        @(posedge clk); #1;
        d = '{32'h0BAD_F00D, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F};
        send_pkt({8'h7E, 8'h41, 8'hFE, 8'h01}, d);
        drain();
        check(exp_q.size() == 0, "R1", "header after reset", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule